// File: doc/BRIEF.md
# Sequential Bfloat16 Multiplier

This block multiplies two 16-bit brain-float operands over several clock cycles. A caller presents both operands with a one-cycle `start` strobe while the unit is idle. Operands that settle the answer directly (NaN, infinity, zero) finish in one cycle. All others are reduced to 8-bit significands. A denormal operand is first shifted up to a leading one, and the shift count is charged against the exponent. The two significands are then multiplied by an iterative shift-and-add engine, one multiplier bit per cycle.

The 16-bit product is renormalised and truncated to seven fraction bits, then packed. An exponent that is too large saturates to infinity. A slightly negative exponent gives a denormal result by right-shifting the fraction. A strongly negative exponent collapses to a signed zero. Completion is marked by a single-cycle `done` pulse, and `result` holds its value until the next completion. `start` has no effect while `busy` is high.

Top module: `bf16_mul_seq`

## Requirements
- R1: After a synchronous active-low reset, `done` and `busy` are 0 and `result` is 0x0000.
- R2: Outside the NaN rules, bit 15 of every result is the XOR of bit 15 of both operands. This also applies to infinities and zeros.
- R3: An operand whose exponent field (bits 14:7) is all ones with a nonzero fraction (bits 6:0) is a NaN. A NaN in `op_a` is returned unchanged. Otherwise a NaN in `op_b` is returned unchanged.
- R4: If one operand is infinite (exponent all ones, fraction zero) and neither is a NaN, the result depends on the other operand. If the other operand is zero, the result is 0x7FC0. Otherwise the result is the XOR sign followed by 0x7F80.
- R5: If neither operand is NaN or infinite and either has exponent and fraction both zero, the result is a zero carrying the XOR sign.
- R6: A denormal operand (exponent 0, fraction nonzero) is shifted left until significand bit 7 is one, and is then treated as exponent 1 minus the shift count. Example: 0x0001 × 0x4B00 = 0x0880.
- R7: Normal significands are 1.fraction (8 bits), and their 16-bit product is p. The working exponent is expA + expB − 127, less any denormal shifts. If p[15] is set, the fraction is p[14:8] and the exponent is raised by one; otherwise the fraction is p[13:7]. Example: 0x3F80 × 0x3F00 = 0x3F00.
- R8: If the final exponent is 255 or more, the result is the XOR sign with 0x7F80.
- R9: If the final exponent e satisfies −6 ≤ e ≤ 0, the fraction is shifted right by 1 − e and the exponent field becomes 0. Example: 0x00C0 × 0x3F00 = 0x0020.
- R10: If the final exponent is below −6, the result is a zero carrying the XOR sign.
- R11: For a special operand (R3 to R5), `done` is high in the cycle right after the edge that samples `start`. Otherwise `busy` is high for eight cycles and `done` rises one edge later, nine cycles after the sampling edge.
- R12: A `start` raised while `busy` is high is ignored. The running operation completes with its own operands, and no extra `done` follows.
- R13: `done` lasts exactly one cycle. `result` changes only together with `done` and keeps its value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| busy | output | 1 | Iterative product in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Bfloat16 product, held between completions |

## Verification
If the iteration counter or multiplier register is corrupted, the latency moves off nine cycles, or `busy` outlives its eight-cycle bound, on the very first computed product. A wrong latched exponent or denormal shift count shows up in the first result whose exponent is compared. It does not need an overflow case to appear. Faulty special-case priority or operand latching appears in the cycle after `start`, as a result that breaks the NaN, infinity or zero rules. The random operands are biased toward tiny and huge exponents, so the underflow and overflow boundaries are reached within a few hundred operations.

// File: rtl/bf16_mul_pkg.sv
// Shared definitions for the sequential bfloat16 multiplier.
// Assumes: the format is sign, EXP_W exponent bits, MAN_W fraction bits.
package bf16_mul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;

    // Quiet-NaN pattern: positive sign, exponent all ones, top fraction bit set.
    function automatic logic [15:0] qnan16();
        return 16'h7FC0;
    endfunction

endpackage

// File: rtl/bf16_mul_classify.sv
// Classifies one operand and produces its normalised significand.
// Assumes: the sign bit is removed by the caller; for a zero operand the
// significand, exponent and shift outputs are don't-care.
module bf16_mul_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 7,
    localparam int SIG_W = MAN_W + 1,
    localparam int LZ_W  = $clog2(SIG_W)
) (
    input  logic [EXP_W+MAN_W-1:0] mag,
    output logic                   is_nan,
    output logic                   is_inf,
    output logic                   is_zero,
    output logic [EXP_W-1:0]       exp_eff,
    output logic [SIG_W-1:0]       sig,
    output logic [LZ_W-1:0]        shift
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    int               msb;

    assign ex = mag[EXP_W+MAN_W-1:MAN_W];
    assign mn = mag[MAN_W-1:0];

    // Flag the operand class from the exponent and fraction fields.
    always_comb begin
        is_nan  = (&ex) && (|mn);
        is_inf  = (&ex) && !(|mn);
        is_zero = !(|ex) && !(|mn);
    end

    // Locate the leading one of a denormal fraction and shift it to bit MAN_W.
    always_comb begin
        msb = 0;
        for (int i = 0; i < MAN_W; i++) begin
            if (mn[i]) msb = i;
        end
        if (|ex) begin
            sig     = {1'b1, mn};
            exp_eff = ex;
            shift   = '0;
        end else begin
            sig     = SIG_W'({1'b0, mn} << (MAN_W - msb));
            exp_eff = EXP_W'(1);
            shift   = LZ_W'(MAN_W - msb);
        end
    end
endmodule

// File: rtl/bf16_mul_special.sv
// Resolves operand combinations whose product needs no arithmetic.
// Assumes: index 0 is operand A, index 1 is operand B; A's NaN wins over B's.
module bf16_mul_special #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 7,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [1:0]   nan,
    input  logic [1:0]   inf,
    input  logic [1:0]   zero,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sign,
    output logic         hit,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    // Priority: NaN A, NaN B, infinity (with or without zero), zero.
    always_comb begin
        hit   = 1'b1;
        value = '0;
        if (nan[0]) begin
            value = op_a;
        end else if (nan[1]) begin
            value = op_b;
        end else if (|inf) begin
            value = (|zero) ? QNAN : {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (|zero) begin
            value = {sign, {(W-1){1'b0}}};
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/bf16_mul_shiftadd.sv
// Iterative unsigned significand multiplier, one multiplier bit per step.
// Assumes: the multiplier has its top bit set, so it finishes in SIG_W steps.
// Exposes only the product bits the packer consumes (top SIG_W+1 bits).
module bf16_mul_shiftadd #(
    parameter int SIG_W = 8,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SIG_W-1:0] mcand_in,
    input  logic [SIG_W-1:0] mplier_in,
    output logic             last,
    output logic [SIG_W:0]   prod_hi
);
    logic [PROD_W-1:0] mcand_q, acc_q, acc_nx;
    logic [SIG_W-1:0]  mplier_q, mplier_nx;

    // Next step: add the shifted multiplicand when the current LSB is one.
    always_comb begin
        acc_nx    = acc_q + (mplier_q[0] ? mcand_q : '0);
        mplier_nx = mplier_q >> 1;
    end

    assign last    = step && (mplier_nx == '0);
    assign prod_hi = acc_nx[PROD_W-1:SIG_W-1];

    // Load the operands, or advance one bit of the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= PROD_W'(mcand_in);
            mplier_q <= mplier_in;
            acc_q    <= '0;
        end else if (step) begin
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_nx;
            acc_q    <= acc_nx;
        end
    end
endmodule

// File: rtl/bf16_mul_pack.sv
// Renormalises the product, applies overflow and underflow, packs the word.
// Assumes: prod_hi holds product bits [2*SIG_W-1 : SIG_W-1]; truncation only.
module bf16_mul_pack #(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 7,
    parameter int GRAD_MIN = 6,
    localparam int SIG_W   = MAN_W + 1,
    localparam int EW      = EXP_W + 3,
    localparam int W       = 1 + EXP_W + MAN_W,
    localparam int EXP_MAX = (1 << EXP_W) - 1
) (
    input  logic                 sign,
    input  logic signed [EW-1:0] exp_in,
    input  logic [SIG_W:0]       prod_hi,
    output logic [W-1:0]         packed_out
);
    int               e;
    logic [MAN_W-1:0] m;

    // Select the fraction window, then clamp the exponent range.
    always_comb begin
        if (prod_hi[SIG_W]) begin
            m = prod_hi[SIG_W-1:1];
            e = int'(exp_in) + 1;
        end else begin
            m = prod_hi[MAN_W-1:0];
            e = int'(exp_in);
        end
        if (e >= EXP_MAX) begin
            packed_out = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (e < -GRAD_MIN) begin
            packed_out = {sign, {(W-1){1'b0}}};
        end else if (e <= 0) begin
            packed_out = {sign, {EXP_W{1'b0}}, MAN_W'(m >> (1 - e))};
        end else begin
            packed_out = {sign, EXP_W'(e), m};
        end
    end
endmodule

// File: rtl/bf16_mul_seq.sv
// Top level: accepts operands on start, resolves special cases in one cycle,
// otherwise runs the shift-and-add engine and packs the truncated product.
// Assumes: start is only honoured while idle; result is held between dones.
module bf16_mul_seq #(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 7,
    parameter int GRAD_MIN = 6,
    localparam int W       = 1 + EXP_W + MAN_W,
    localparam int SIG_W   = MAN_W + 1,
    localparam int LZ_W    = $clog2(SIG_W),
    localparam int EW      = EXP_W + 3,
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    import bf16_mul_pkg::*;

    mul_state_t           state_q;
    logic [W-2:0]         mag [2];
    logic [1:0]           c_nan, c_inf, c_zero;
    logic [EXP_W-1:0]     c_exp [2];
    logic [SIG_W-1:0]     c_sig [2];
    logic [LZ_W-1:0]      c_shift [2];
    logic                 sign_nx, sign_q;
    logic                 sp_hit;
    logic [W-1:0]         sp_value;
    logic signed [EW-1:0] exp_nx, exp_q;
    logic                 accept, mul_load, mul_last;
    logic [SIG_W:0]       prod_hi;
    logic [W-1:0]         pack_out;

    assign mag[0]  = op_a[W-2:0];
    assign mag[1]  = op_b[W-2:0];
    assign sign_nx = op_a[W-1] ^ op_b[W-1];
    assign accept  = (state_q == ST_IDLE) && start;
    assign mul_load = accept && !sp_hit;
    assign busy    = (state_q == ST_RUN);

    // One classifier per operand.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        bf16_mul_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .mag     (mag[g]),
            .is_nan  (c_nan[g]),
            .is_inf  (c_inf[g]),
            .is_zero (c_zero[g]),
            .exp_eff (c_exp[g]),
            .sig     (c_sig[g]),
            .shift   (c_shift[g])
        );
    end

    bf16_mul_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_special (
        .nan   (c_nan),
        .inf   (c_inf),
        .zero  (c_zero),
        .op_a  (op_a),
        .op_b  (op_b),
        .sign  (sign_nx),
        .hit   (sp_hit),
        .value (sp_value)
    );

    // Biased exponent sum less the denormal shift counts.
    always_comb begin
        exp_nx = EW'(int'(c_exp[0]) + int'(c_exp[1]) - BIAS
                     - int'(c_shift[0]) - int'(c_shift[1]));
    end

    bf16_mul_shiftadd #(.SIG_W(SIG_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mul_load),
        .step      (busy),
        .mcand_in  (c_sig[0]),
        .mplier_in (c_sig[1]),
        .last      (mul_last),
        .prod_hi   (prod_hi)
    );

    bf16_mul_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRAD_MIN(GRAD_MIN)) u_pack (
        .sign       (sign_q),
        .exp_in     (exp_q),
        .prod_hi    (prod_hi),
        .packed_out (pack_out)
    );

    // Control: take operands, finish special cases at once, else iterate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            result  <= '0;
            sign_q  <= 1'b0;
            exp_q   <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sign_q <= sign_nx;
                        exp_q  <= exp_nx;
                        if (sp_hit) begin
                            result <= sp_value;
                            done   <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (mul_last) begin
                        result  <= pack_out;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bf16_mul_seq_chk.sv
// Port-level checker for bf16_mul_seq, attached by bind.
// Assumes: it sees the same operands the top samples on an accepted start.
module bf16_mul_seq_chk #(
    parameter int W     = 16,
    parameter int EXP_W = 8,
    parameter int MAN_W = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    localparam int SIG_W = MAN_W + 1;

    logic [W-1:0] a_q, b_q;
    int           run_cnt;
    logic         a_nan, a_exp1, b_exp1;

    // Remember the operands of the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start && !busy) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= 0;
        else        run_cnt <= busy ? run_cnt + 1 : 0;
    end

    assign a_nan  = (&a_q[W-2:MAN_W]) && (|a_q[MAN_W-1:0]);
    assign a_exp1 = &a_q[W-2:MAN_W];
    assign b_exp1 = &b_q[W-2:MAN_W];

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt < SIG_W);

    // R12
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));

    // R3
    nan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && a_nan) |-> result == a_q);

    // R2
    sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !a_exp1 && !b_exp1) |-> result[W-1] == (a_q[W-1] ^ b_q[W-1]));
endmodule

bind bf16_mul_seq bf16_mul_seq_chk #(.W(16), .EXP_W(8), .MAN_W(7)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/bf16_mul_seq_tb.sv
module bf16_mul_seq_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        busy, done;
    logic [15:0] result;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bf16_mul_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    // True when the operands settle the product without arithmetic.
    function automatic bit is_special(input logic [15:0] a, input logic [15:0] b);
        return (a[14:7] == 8'hFF) || (b[14:7] == 8'hFF) ||
               (a[14:0] == 15'd0) || (b[14:0] == 15'd0);
    endfunction

    // Expected product from the requirements.
    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
        int s, ea, eb, xa, xb, adj, p, e, m;
        bit za, zb;
        s  = a[15] ^ b[15];
        ea = a[14:7]; eb = b[14:7];
        xa = a[6:0];  xb = b[6:0];
        za = (ea == 0) && (xa == 0);
        zb = (eb == 0) && (xb == 0);
        if (ea == 255 && xa != 0) return a;
        if (eb == 255 && xb != 0) return b;
        if (ea == 255 || eb == 255) return (za || zb) ? 16'h7FC0 : 16'((s << 15) | 32'h7F80);
        if (za || zb) return 16'(s << 15);
        adj = 0;
        if (ea == 0) begin
            while ((xa & 32'h80) == 0) begin xa = xa << 1; adj--; end
            ea = 1;
        end else xa = xa | 32'h80;
        if (eb == 0) begin
            while ((xb & 32'h80) == 0) begin xb = xb << 1; adj--; end
            eb = 1;
        end else xb = xb | 32'h80;
        p = xa * xb;
        e = ea + eb - 127 + adj;
        if ((p & 32'h8000) != 0) begin m = (p >> 8) & 32'h7F; e++; end
        else m = (p >> 7) & 32'h7F;
        if (e >= 255) return 16'((s << 15) | 32'h7F80);
        if (e < -6) return 16'(s << 15);
        if (e <= 0) begin m = m >> (1 - e); e = 0; end
        return 16'((s << 15) | (e << 7) | m);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Run one operation; check value and latency (R11).
    task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b);
        int lat;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        check(req, result, model(a, b));
        check_int("R11 latency", lat, is_special(a, b) ? 1 : 9);
    endtask

    function automatic logic [15:0] rand_op();
        logic [7:0] ex;
        logic [6:0] mn;
        int sel;
        sel = $urandom % 8;
        mn  = 7'($urandom);
        case (sel)
            0: ex = 8'd0;
            1: ex = 8'(1 + $urandom % 12);
            2: ex = 8'(244 + $urandom % 11);
            3: ex = 8'hFF;
            default: ex = 8'(90 + $urandom % 70);
        endcase
        return {1'($urandom), ex, mn};
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold;
        int pulses;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 result", result, 16'h0000);
        rst_n = 1'b1;

        run_op("R7 one times half", 16'h3F80, 16'h3F00);
        check("R7 literal", result, 16'h3F00);
        run_op("R2 negative product", 16'hC040, 16'h4040);
        run_op("R3 nan a", 16'h7FC1, 16'h3F80);
        check("R3 literal", result, 16'h7FC1);
        run_op("R3 nan b", 16'h4000, 16'hFF85);
        check("R3 literal b", result, 16'hFF85);
        run_op("R4 inf times zero", 16'h7F80, 16'h0000);
        check("R4 literal", result, 16'h7FC0);
        run_op("R4 neg inf", 16'hFF80, 16'h3F80);
        check("R4 literal sign", result, 16'hFF80);
        run_op("R5 signed zero", 16'h0000, 16'hC000);
        check("R5 literal", result, 16'h8000);
        run_op("R6 denormal", 16'h0001, 16'h4B00);
        check("R6 literal", result, 16'h0880);
        run_op("R8 overflow", 16'h7F00, 16'h7F00);
        check("R8 literal", result, 16'h7F80);
        run_op("R9 gradual", 16'h00C0, 16'h3F00);
        check("R9 literal", result, 16'h0020);
        run_op("R10 flush", 16'h8080, 16'h0080);
        check("R10 literal", result, 16'h8000);

        // R13: result held and done low after completion
        hold = result;
        repeat (3) @(negedge clk);
        check("R13 hold", result, hold);
        check("R13 pulse", {15'd0, done}, 16'd0);

        // R12: start while busy is ignored
        @(negedge clk);
        op_a = 16'h4000; op_b = 16'h4040; start = 1'b1;
        @(negedge clk);
        op_a = 16'h7FC3; op_b = 16'h3F80;
        pulses = 0;
        repeat (3) begin
            @(negedge clk);
            if (done) pulses++;
        end
        start = 1'b0;
        repeat (14) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check("R12 result", result, model(16'h4000, 16'h4040));
        check_int("R12 done count", pulses, 1);

        for (int i = 0; i < 600; i++) begin
            logic [15:0] ra, rb;
            ra = rand_op();
            rb = rand_op();
            run_op("R7 random", ra, rb);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule